// File: doc/BRIEF.md
# Pin Mode and Status Multiplexer

This block manages three bidirectional I/O pins. Each pin has its own host control bits. A pin can be a plain digital input, a push-pull digital output, or an active-low status indicator. In status mode the pin is pulled low while its internal condition is true and is released to the external pull-up otherwise.

Each pin has a fixed status source:
- Pin 0 shows the charging condition, or the C/x-reached condition when the battery type is sealed lead-acid.
- Pin 1 shows a sticky backup-fault flag that the block holds itself.
- Pin 2 shows calibration-complete, or the charge-fault condition when the block is strapped for standalone operation with no host.

The host reaches the block through a small register port. A write takes effect at the clock edge; a read is combinational.

| Address | Contents |
|---|---|
| 0 | Enable bits |
| 1 | Output-data bits |
| 2 | Status-select bits |
| 3 | Read: bit 0 is the backup-fault flag, bits 3:1 are the synchronized pin levels of pins 2..0. Write: a 1 in bit 0 clears the flag. |

In every register, bit *i* belongs to pin *i*. A standalone strap makes every pin come out of reset in status mode. An undervoltage or shutdown indication forces the enable bits back to their defaults.

Top module: `gpio_mode_status_top`

## Requirements
- R1: A pin whose enable bit is 0 is an input: `pin_oe` is 0 for that pin, whatever its output-data and status-select bits hold.
- R2: A pin with enable 1 and status-select 0 is a digital output: `pin_oe` is 1 and `pin_out` equals its output-data bit.
- R3: A pin with enable 1 and status-select 1 is a status output and its output-data bit has no effect. It drives 0 (`pin_oe`=1, `pin_out`=0) while its condition is true and has `pin_oe`=0 while the condition is false.
- R4: The pin 0 condition is `chg_state[0] | chg_state[1]` when `sla_type`=0, and `cx_reached` when `sla_type`=1.
- R5: The pin 1 condition is the backup-fault flag.
- R6: The pin 2 condition is `cal_done` when `strap_standalone`=0, and `chg_fault` when `strap_standalone`=1.
- R7: The backup-fault flag reads at address 3 bit 0. A `backup_fault_evt` high at a clock edge sets it. It stays set until a write of 1 to address 3 bit 0 clears it. If both happen at the same edge, the flag ends up set.
- R8: With `strap_standalone`=1, reset leaves the enable and status-select bits of all pins at 1. Host writes can still change them afterwards.
- R9: While `uvlo_shdn` is 1 at a clock edge, the enable bits are loaded with their default value (all 1 when strapped standalone, all 0 otherwise), and a host write to address 0 is ignored. Output-data and status-select bits keep their contents.
- R10: Address 3 bits 3:1 give each pin's level as it was two clock edges earlier (two-flop synchronizer). This holds in every mode, so a driven pin reads back its own driven value.
- R11: With `strap_standalone`=0, reset leaves all control bits and the flag at 0 and all pins undriven.
- R12: Addresses 0, 1 and 2 read back the bits last written, in bits 2:0. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_standalone | input | 1 | Static strap: no host present, status mode at power-up |
| uvlo_shdn | input | 1 | Undervoltage/shutdown indication, restores enable defaults |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address (read and write) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| chg_state | input | 2 | Charge-state bits |
| cx_reached | input | 1 | C/x point of the charge cycle reached |
| sla_type | input | 1 | Battery type is sealed lead-acid |
| backup_fault_evt | input | 1 | Backup-fault event, sets the sticky flag |
| chg_fault | input | 1 | Charge-fault bit |
| cal_done | input | 1 | Calibration-complete condition |
| pin_in | input | 3 | Pin levels as seen at the pads |
| pin_out | output | 3 | Pin output data |
| pin_oe | output | 3 | Pin output enable (0 is high-impedance) |

## Verification
The bench drives random writes with mixed enable, data and select patterns across the pins. This separates per-pin independence from cross-pin leakage, and shows whether the output-data bit really drops out in status mode. Status inputs are randomized under both strap settings and both battery types, which shows whether the right source reaches each pin. Directed steps cover the same-edge set and clear of the sticky flag, a host enable write during undervoltage, and a pin level change observed one edge and then two edges later. These expose an off-by-one synchronizer depth or a swapped priority.

// File: rtl/gpsm_pkg.sv
package gpsm_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_OUT  = 2'd1,
    REG_SEL  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_CHARGE = 2'd0,
    SRC_BACKUP = 2'd1,
    SRC_CALIB  = 2'd2
  } status_src_e;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'd0,
    MODE_DRIVE  = 2'd1,
    MODE_STATUS = 2'd2
  } pin_mode_e;

  typedef struct packed {
    logic [1:0] chg_state;
    logic       cx_reached;
    logic       sla_type;
    logic       chg_fault;
    logic       cal_done;
  } charger_status_t;

  function automatic status_src_e src_for_pin(input int idx);
    case (idx % 3)
      0:       return SRC_CHARGE;
      1:       return SRC_BACKUP;
      default: return SRC_CALIB;
    endcase
  endfunction

  function automatic pin_mode_e decode_mode(input logic en, input logic sel);
    if (!en)     return MODE_INPUT;
    else if (sel) return MODE_STATUS;
    else         return MODE_DRIVE;
  endfunction

endpackage

// File: rtl/gpsm_rst_sync.sv
module gpsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpsm_in_sync.sv
module gpsm_in_sync #(
  parameter int NUM_PINS = 3,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_sync
);

  logic [NUM_PINS-1:0] stage_q [STAGES];
  logic [NUM_PINS-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm_q;
      logic [1:0] warm_d;
      always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
      end
      // R10: readable level equals the pad level two edges back
      p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (pin_sync == $past(pin_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpsm_ctrl_regs.sv
module gpsm_ctrl_regs
  import gpsm_pkg::*;
#(
  parameter int NUM_PINS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_standalone,
  input  logic                  uvlo_shdn,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  fault_event,
  input  logic [NUM_PINS-1:0]   pin_level_sync,
  output logic [NUM_PINS-1:0]   en_q,
  output logic [NUM_PINS-1:0]   out_q,
  output logic [NUM_PINS-1:0]   sel_q,
  output logic                  bkup_flag_q
);

  logic [NUM_PINS-1:0] en_def;
  logic [NUM_PINS-1:0] en_d, out_d, sel_d;
  logic                flag_d;
  logic                wr_en_reg, wr_out_reg, wr_sel_reg, clr_req;
  logic                en_ce, out_ce, sel_ce;

  generate
    if (DATA_W > NUM_PINS) begin : g_spare
      logic unused_wdata_bits;
      assign unused_wdata_bits = ^wr_data[DATA_W-1:NUM_PINS];
    end
  endgenerate

  always_comb begin
    en_def     = strap_standalone ? '1 : '0;
    wr_en_reg  = wr_en && (reg_addr_e'(addr) == REG_EN);
    wr_out_reg = wr_en && (reg_addr_e'(addr) == REG_OUT);
    wr_sel_reg = wr_en && (reg_addr_e'(addr) == REG_SEL);
    clr_req    = wr_en && (reg_addr_e'(addr) == REG_STAT) && wr_data[0];

    en_ce  = uvlo_shdn || wr_en_reg;
    out_ce = wr_out_reg;
    sel_ce = wr_sel_reg;

    en_d   = uvlo_shdn ? en_def : wr_data[NUM_PINS-1:0];
    out_d  = wr_data[NUM_PINS-1:0];
    sel_d  = wr_data[NUM_PINS-1:0];

    flag_d = bkup_flag_q;
    if (fault_event)  flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= en_def;
      out_q       <= '0;
      sel_q       <= en_def;
      bkup_flag_q <= 1'b0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (out_ce) out_q <= out_d;
      if (sel_ce) sel_q <= sel_d;
      bkup_flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_addr_e'(addr))
      REG_EN:   rd_data[NUM_PINS-1:0] = en_q;
      REG_OUT:  rd_data[NUM_PINS-1:0] = out_q;
      REG_SEL:  rd_data[NUM_PINS-1:0] = sel_q;
      REG_STAT: begin
        rd_data[0]          = bkup_flag_q;
        rd_data[NUM_PINS:1] = pin_level_sync;
      end
    endcase
  end

  // R7: an event sets the flag at the next edge
  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_event |=> bkup_flag_q);
  // R7: without a clear request the flag stays set
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup_flag_q && !(wr_en && addr == REG_STAT && wr_data[0])) |=> bkup_flag_q);
  // R7: a clear with no coincident event drops the flag
  p_sticky_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_STAT && wr_data[0] && !fault_event) |=> !bkup_flag_q);
  // R9: undervoltage restores enable defaults, overriding a host write
  p_uvlo_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_shdn |=> (en_q == $past(en_def)));
  // R9: undervoltage leaves the output-data bits alone
  p_uvlo_keeps_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_shdn && !(wr_en && addr == REG_OUT)) |=> $stable(out_q));

endmodule

// File: rtl/gpsm_status_sel.sv
module gpsm_status_sel
  import gpsm_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  charger_status_t     chg_stat,
  input  logic                bkup_flag,
  input  logic                no_host,
  output logic [NUM_PINS-1:0] status_true
);

  logic charge_cond;
  logic calib_cond;

  always_comb begin
    charge_cond = chg_stat.sla_type ? chg_stat.cx_reached : (|chg_stat.chg_state);
    calib_cond  = no_host ? chg_stat.chg_fault : chg_stat.cal_done;
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_src
      localparam status_src_e SRC = src_for_pin(i);
      if (SRC == SRC_CHARGE) begin : g_charge
        assign status_true[i] = charge_cond;
      end else if (SRC == SRC_BACKUP) begin : g_backup
        assign status_true[i] = bkup_flag;
      end else begin : g_calib
        assign status_true[i] = calib_cond;
      end
    end
  endgenerate

endmodule

// File: rtl/gpsm_pin_ctrl.sv
module gpsm_pin_ctrl
  import gpsm_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] out_bit,
  input  logic [NUM_PINS-1:0] sel,
  input  logic [NUM_PINS-1:0] status_true,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_mode_e mode;
      logic      oe_l;
      logic      dat_l;
      always_comb begin
        mode  = decode_mode(en[i], sel[i]);
        oe_l  = 1'b0;
        dat_l = 1'b0;
        unique case (mode)
          MODE_INPUT:  begin oe_l = 1'b0;           dat_l = 1'b0;       end
          MODE_DRIVE:  begin oe_l = 1'b1;           dat_l = out_bit[i]; end
          MODE_STATUS: begin oe_l = status_true[i]; dat_l = 1'b0;       end
          default:     begin oe_l = 1'b0;           dat_l = 1'b0;       end
        endcase
      end
      assign pin_oe[i]  = oe_l;
      assign pin_out[i] = dat_l;
    end
  endgenerate

endmodule

// File: rtl/gpio_mode_status_top.sv
module gpio_mode_status_top
  import gpsm_pkg::*;
#(
  parameter int NUM_PINS   = 3,
  parameter int DATA_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_standalone,
  input  logic                  uvlo_shdn,
  input  logic                  host_wr,
  input  logic [REG_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic [DATA_W-1:0]     host_rdata,
  input  logic [1:0]            chg_state,
  input  logic                  cx_reached,
  input  logic                  sla_type,
  input  logic                  backup_fault_evt,
  input  logic                  chg_fault,
  input  logic                  cal_done,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe
);

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] en_q, out_q, sel_q;
  logic                bkup_flag_q;
  logic [NUM_PINS-1:0] status_true;
  charger_status_t     chg_stat;

  assign chg_stat = '{chg_state: chg_state, cx_reached: cx_reached, sla_type: sla_type,
                      chg_fault: chg_fault, cal_done: cal_done};

  gpsm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  gpsm_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpsm_ctrl_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .strap_standalone(strap_standalone),
    .uvlo_shdn(uvlo_shdn), .wr_en(host_wr), .addr(host_addr),
    .wr_data(host_wdata), .rd_data(host_rdata), .fault_event(backup_fault_evt),
    .pin_level_sync(pin_sync), .en_q(en_q), .out_q(out_q), .sel_q(sel_q),
    .bkup_flag_q(bkup_flag_q)
  );

  gpsm_status_sel #(.NUM_PINS(NUM_PINS)) u_stat (
    .chg_stat(chg_stat), .bkup_flag(bkup_flag_q), .no_host(strap_standalone),
    .status_true(status_true)
  );

  gpsm_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_pins (
    .en(en_q), .out_bit(out_q), .sel(sel_q), .status_true(status_true),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // R1: disabled pins are never driven
  p_hiz_when_off_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pin_oe & ~en_q) == '0));
  // R2: enabled non-status pins are always driven
  p_drive_on_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((en_q & ~sel_q & ~pin_oe) == '0));
  // R3: a status pin only ever pulls low
  p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pin_oe & en_q & sel_q & pin_out) == '0));

endmodule

// File: tb/gpio_mode_status_top_tb_top.sv
module gpio_mode_status_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, strap, uvlo, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0] chg_state;
  logic       cx, sla, fev, cfault, cdone;
  logic [N-1:0] ext_lvl, pin_in, pin_out, pin_oe;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_mode_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .strap_standalone(strap), .uvlo_shdn(uvlo),
    .host_wr(wr), .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .chg_state(chg_state), .cx_reached(cx), .sla_type(sla),
    .backup_fault_evt(fev), .chg_fault(cfault), .cal_done(cdone),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_en, m_out, m_sel, m_s1, m_s2;
  logic m_flag;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] def_en();
    return strap ? '1 : '0;
  endfunction

  function automatic logic cond_for(input int i);
    if (i == 0) return sla ? cx : (chg_state[0] | chg_state[1]);
    if (i == 1) return m_flag;
    return strap ? cfault : cdone;
  endfunction

  function automatic string tag_for(input int i);
    if (!m_en[i]) return "R1";
    if (!m_sel[i]) return "R2";
    if (i == 0) return "R3/R4";
    if (i == 1) return "R3/R5";
    return "R3/R6";
  endfunction

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      logic eo, ed;
      if (!m_en[i])       begin eo = 1'b0; ed = 1'b0; end
      else if (!m_sel[i]) begin eo = 1'b1; ed = m_out[i]; end
      else                begin eo = cond_for(i); ed = 1'b0; end
      chk(tag_for(i), int'(pin_oe[i]), int'(eo), $sformatf("pin%0d oe", i));
      if (eo) chk(tag_for(i), int'(pin_out[i]), int'(ed), $sformatf("pin%0d out", i));
    end
    case (addr)
      2'd0: chk("R12", int'(rdata), int'({5'd0, m_en}), "read enable");
      2'd1: chk("R12", int'(rdata), int'({5'd0, m_out}), "read data");
      2'd2: chk("R12", int'(rdata), int'({5'd0, m_sel}), "read select");
      default: begin
        chk("R7", int'(rdata[0]), int'(m_flag), "read flag");
        chk("R10", int'(rdata[7:1]), int'({4'd0, m_s2}), "read levels");
      end
    endcase
  endtask

  // inputs already placed at a negedge; clock once, update model, check
  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                      input logic uv, input logic fe);
    logic [N-1:0] lvl;
    wr = w; addr = a; wdata = d; uvlo = uv; fev = fe;
    #1 lvl = pin_in;
    @(posedge clk);
    if (uv) m_en = def_en();
    else if (w && a == 2'd0) m_en = d[N-1:0];
    if (w && a == 2'd1) m_out = d[N-1:0];
    if (w && a == 2'd2) m_sel = d[N-1:0];
    if (fe) m_flag = 1'b1;
    else if (w && a == 2'd3 && d[0]) m_flag = 1'b0;
    m_s2 = m_s1; m_s1 = lvl;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_inputs();
    wr = 0; addr = 0; wdata = 0; uvlo = 0; fev = 0;
    chg_state = 0; cx = 0; sla = 0; cfault = 0; cdone = 0; ext_lvl = '1;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 0; strap = s; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    m_en = def_en(); m_sel = def_en(); m_out = '0; m_flag = 0;
    m_s1 = pin_in; m_s2 = pin_in;
    addr = 2'd0;
    #1;
    if (!s) begin
      chk("R11", int'(pin_oe), 0, "oe after reset");
      chk("R11", int'(rdata), 0, "enable after reset");
    end else begin
      chk("R8", int'(rdata), 7, "enable after strapped reset");
    end
    check_all();
  endtask

  task automatic rand_steps(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] d;
      chg_state = 2'($urandom); cx = 1'($urandom); sla = 1'($urandom);
      cfault = 1'($urandom); cdone = 1'($urandom); ext_lvl = N'($urandom);
      d = 8'($urandom);
      step(($urandom % 2) == 0, 2'($urandom), d, ($urandom % 20) == 0,
           ($urandom % 10) == 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    rst_n = 0; strap = 0; idle_inputs();

    // ---- host-present phase ----
    do_reset(1'b0);
    step(1, 2'd1, 8'h05, 0, 0);               // R12 write output data
    step(1, 2'd0, 8'h07, 0, 0);               // R2 all driven
    chk("R2", int'(pin_oe), 7, "all pins driven");
    chk("R2", int'(pin_out), 5, "driven values");
    chg_state = 2'b01;
    step(1, 2'd2, 8'h01, 0, 0);               // R3 pin0 status, out bit 1 ignored
    chk("R3", int'({pin_oe[0], pin_out[0]}), 2, "pin0 pulls low");
    sla = 1; cx = 0; chg_state = 2'b11;
    step(0, 2'd0, 8'h00, 0, 0);               // R4 sealed lead-acid hides charge
    chk("R4", int'(pin_oe[0]), 0, "pin0 released under SLA");
    step(1, 2'd2, 8'h07, 0, 1);               // R7 set flag
    chk("R5", int'(pin_oe[1]), 1, "pin1 shows flag");
    step(1, 2'd3, 8'h01, 0, 1);               // R7 set wins over clear
    chk("R7", int'(rdata[0]), 1, "set beats clear");
    step(1, 2'd3, 8'h01, 0, 0);               // R7 clear
    chk("R7", int'(rdata[0]), 0, "flag cleared");
    step(1, 2'd0, 8'h03, 1, 0);               // R9 uvlo beats write
    addr = 2'd0; #1;
    chk("R9", int'(rdata), 0, "enables to default");
    addr = 2'd1; #1;
    chk("R9", int'(rdata), 5, "output data kept");
    ext_lvl = 3'b010;
    step(0, 2'd3, 8'h00, 0, 0);               // R10 one edge: old level
    chk("R10", int'(rdata[3:1]), 7, "one edge after change");
    step(0, 2'd3, 8'h00, 0, 0);               // R10 two edges: new level
    chk("R10", int'(rdata[3:1]), 2, "two edges after change");
    rand_steps(4000);

    // ---- standalone phase ----
    do_reset(1'b1);
    addr = 2'd2; #1;
    chk("R8", int'(rdata), 7, "select after strapped reset");
    cfault = 1; cdone = 0;
    step(0, 2'd2, 8'h00, 0, 0);
    chk("R6", int'(pin_oe[2]), 1, "pin2 shows charge fault");
    step(1, 2'd0, 8'h00, 0, 0);               // R8 host can still rewrite
    chk("R8", int'(pin_oe), 0, "host disabled pins");
    step(0, 2'd0, 8'h00, 1, 0);               // R9 default is all ones here
    chk("R9", int'(rdata), 7, "strapped enable default");
    rand_steps(4000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule